// File: doc/BRIEF.md
# Hypervisor Interrupt Control Register File

This block keeps the hypervisor-level interrupt configuration and status of one hart, together with the guest-supervisor views of interrupt enable and pending. Software reaches it through a simple synchronous register port. The port has a 12-bit address, a write strobe, write data, combinational read data and a flag for addresses that map to nothing. Writes take effect at the rising clock edge.

Beside the stored registers, the block turns several inputs into the derived hypervisor pending bits. These inputs are a vector of guest-external pending lines from an interrupt controller, a selector that picks one of those lines for the guest, and single lines for other guest-directed external and timer interrupts. The guest views are gated by the delegation bits. They move hypervisor bits 2, 6 and 10 down to bits 1, 5 and 9, and writes through them land in the underlying hypervisor bits. The parameter `GEI_NUM` sets the number of guest-external lines and may be zero. The parameter `LCOF_DELEG` makes delegation bit 13 writable.

Top module: `hyp_irq_csr`

## Requirements
- R1: After reset every stored bit is 0. With all interrupt inputs low, every mapped register then reads 0 and `hip_o` is 0.
- R2: The guest-external enable register (0x607) keeps only bits GEI_NUM down to 1. Bit 0 and every bit above GEI_NUM read 0. With GEI_NUM=4, writing all ones reads back 0x1E.
- R3: The guest-external pending register (0xE12) reads `gext_pend_i` with bit 0 and every bit above GEI_NUM cleared. Writes to it have no effect.
- R4: Pending bit 12 (read at 0x608 and on `hip_o`) is 1 exactly when the masked guest-external pending vector and the enable register share a set bit.
- R5: Pending bit 10 is the OR of three sources: virtual-pending bit 10, `vs_ext_irq_i`, and masked guest-external line `vgein_i`. The selector contributes 0 when it is 0 or above GEI_NUM. The enable register at 0x607 plays no part in this bit.
- R6: Pending bit 6 is the OR of virtual-pending bit 6 and `vs_tmr_irq_i`. Pending bit 2 equals virtual-pending bit 2. A write to 0x608 changes only virtual-pending bit 2, which takes wdata bit 2.
- R7: The delegation register (0x603) stores bits 2, 6 and 10, and bit 13 only when LCOF_DELEG is 1. All other bits read 0. With defaults, writing all ones reads 0x444.
- R8: The virtual-pending register (0x645) stores bits 2, 6 and 10, reading 0x444 after an all-ones write. The hypervisor enable register (0x604) stores bits 2, 6, 10 and 12, reading 0x1444 after an all-ones write.
- R9: The guest enable view (0x204) reads enable bits 2, 6 and 10 at bits 1, 5 and 9, each gated by delegation bit 2, 6 or 10. A write sets an enable bit from the matching view bit only while its delegation bit is 1; otherwise it has no effect.
- R10: The guest pending view (0x244) reads pending bits 2, 6 and 10 at bits 1, 5 and 9, with the same gating. A write changes only virtual-pending bit 2, taken from wdata bit 1, and only while delegation bit 2 is 1.
- R11: The guest scratch register (0x240) stores all XLEN bits and affects no other output.
- R12: Any other address raises `csr_unmapped_o` and reads 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_we_i | input | 1 | Write strobe, sampled at the rising edge |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i, combinational |
| csr_unmapped_o | output | 1 | Address decodes to no register |
| gext_pend_i | input | XLEN | Guest-external pending lines from the interrupt controller |
| vgein_i | input | VGEIN_W | Selects which guest-external line feeds pending bit 10 |
| vs_ext_irq_i | input | 1 | Other guest-directed external interrupt |
| vs_tmr_irq_i | input | 1 | Guest-directed timer interrupt |
| hip_o | output | XLEN | Derived hypervisor pending vector (bits 2, 6, 10, 12) |

## Verification
Read data and `hip_o` follow the address and the interrupt inputs in the same cycle, with no register between them. A write becomes visible only after the rising edge that samples the strobe. The bench therefore drives at the falling edge and checks pure reads 1 ns later. For a write, it first lets one rising edge pass, drops the strobe at the next falling edge, and only then reads back the same address. Every table row checks read data and the pending vector together, so each alias and gate is observed in the cycle its stored state changes.

// File: rtl/hyp_irq_pkg.sv
`timescale 1ns/1ps
package hyp_irq_pkg;
  localparam logic [11:0] A_HDELEG  = 12'h603;
  localparam logic [11:0] A_HEN     = 12'h604;
  localparam logic [11:0] A_GEEN    = 12'h607;
  localparam logic [11:0] A_HPEND   = 12'h608;
  localparam logic [11:0] A_HVPEND  = 12'h645;
  localparam logic [11:0] A_GEPEND  = 12'hE12;
  localparam logic [11:0] A_VSEN    = 12'h204;
  localparam logic [11:0] A_VSPEND  = 12'h244;
  localparam logic [11:0] A_VSSCR   = 12'h240;

  // hypervisor bit positions; guest view sits one lower
  localparam int B_SSW  = 2;
  localparam int B_TMR  = 6;
  localparam int B_EXT  = 10;
  localparam int B_SGE  = 12;
  localparam int B_LCOF = 13;
  localparam int VS_SHIFT = 1;

  typedef struct packed {
    logic ext;
    logic tmr;
    logic ssw;
  } vs_bits_t;

  // bits n..1 set
  function automatic logic [63:0] ge_mask_f(int n);
    logic [63:0] m;
    m = '0;
    for (int i = 1; i < 64; i++) if (i <= n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hyp_irq_regs.sv
`timescale 1ns/1ps
module hyp_irq_regs
  import hyp_irq_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int GEI_NUM    = 4,
  parameter bit LCOF_DELEG = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [11:0]     addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output vs_bits_t        deleg_o,
  output logic            deleg_lcof_o,
  output vs_bits_t        hen_o,
  output logic            hen_sge_o,
  output vs_bits_t        hvip_o,
  output logic [XLEN-1:0] geen_o,
  output logic [XLEN-1:0] scratch_o
);
  localparam int LO = B_SSW - VS_SHIFT;
  localparam int MO = B_TMR - VS_SHIFT;
  localparam int HO = B_EXT - VS_SHIFT;

  logic wr_deleg, wr_hen, wr_geen, wr_hpend, wr_hvp, wr_vsen, wr_vspend, wr_scr;

  assign wr_deleg  = we_i && (addr_i == A_HDELEG);
  assign wr_hen    = we_i && (addr_i == A_HEN);
  assign wr_geen   = we_i && (addr_i == A_GEEN);
  assign wr_hpend  = we_i && (addr_i == A_HPEND);
  assign wr_hvp    = we_i && (addr_i == A_HVPEND);
  assign wr_vsen   = we_i && (addr_i == A_VSEN);
  assign wr_vspend = we_i && (addr_i == A_VSPEND);
  assign wr_scr    = we_i && (addr_i == A_VSSCR);

  vs_bits_t deleg_q, hen_q, hvip_q;
  logic     hen_sge_q;
  logic [XLEN-1:0] scratch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deleg_q <= '0;
    end else if (wr_deleg) begin
      deleg_q <= '{ext: wdata_i[B_EXT], tmr: wdata_i[B_TMR], ssw: wdata_i[B_SSW]};
    end
  end

  // enable: direct write, or redirected from guest view per delegated bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hen_q     <= '0;
      hen_sge_q <= 1'b0;
    end else if (wr_hen) begin
      hen_q     <= '{ext: wdata_i[B_EXT], tmr: wdata_i[B_TMR], ssw: wdata_i[B_SSW]};
      hen_sge_q <= wdata_i[B_SGE];
    end else if (wr_vsen) begin
      if (deleg_q.ssw) hen_q.ssw <= wdata_i[LO];
      if (deleg_q.tmr) hen_q.tmr <= wdata_i[MO];
      if (deleg_q.ext) hen_q.ext <= wdata_i[HO];
    end
  end

  // virtual pending: three write paths, only ssw reachable through aliases
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hvip_q <= '0;
    end else if (wr_hvp) begin
      hvip_q <= '{ext: wdata_i[B_EXT], tmr: wdata_i[B_TMR], ssw: wdata_i[B_SSW]};
    end else if (wr_hpend) begin
      hvip_q.ssw <= wdata_i[B_SSW];
    end else if (wr_vspend && deleg_q.ssw) begin
      hvip_q.ssw <= wdata_i[LO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     scratch_q <= '0;
    else if (wr_scr) scratch_q <= wdata_i;
  end

  generate
    if (LCOF_DELEG) begin : g_lcof
      logic lcof_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       lcof_q <= 1'b0;
        else if (wr_deleg) lcof_q <= wdata_i[B_LCOF];
      end
      assign deleg_lcof_o = lcof_q;
    end else begin : g_no_lcof
      assign deleg_lcof_o = 1'b0;
    end

    for (genvar g = 0; g < XLEN; g++) begin : g_geen
      if (g >= 1 && g <= GEI_NUM) begin : g_impl
        logic en_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      en_q <= 1'b0;
          else if (wr_geen) en_q <= wdata_i[g];
        end
        assign geen_o[g] = en_q;
      end else begin : g_zero
        assign geen_o[g] = 1'b0;
      end
    end
  endgenerate

  assign deleg_o   = deleg_q;
  assign hen_o     = hen_q;
  assign hen_sge_o = hen_sge_q;
  assign hvip_o    = hvip_q;
  assign scratch_o = scratch_q;
endmodule

// File: rtl/hyp_irq_pend.sv
`timescale 1ns/1ps
module hyp_irq_pend
  import hyp_irq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GEI_NUM = 4,
  parameter int VGEIN_W = 6
) (
  input  vs_bits_t           hvip_i,
  input  logic [XLEN-1:0]    geen_i,
  input  logic [XLEN-1:0]    gext_pend_i,
  input  logic [VGEIN_W-1:0] vgein_i,
  input  logic               vs_ext_irq_i,
  input  logic               vs_tmr_irq_i,
  output logic [XLEN-1:0]    gpend_o,
  output vs_bits_t           hpend_o,
  output logic               sgeip_o
);
  localparam logic [XLEN-1:0] GE_MASK = XLEN'(ge_mask_f(GEI_NUM));

  logic sel_line;

  assign gpend_o = gext_pend_i & GE_MASK;
  assign sgeip_o = |(gpend_o & geen_i);

  // selector outside 1..GEI_NUM picks nothing
  always_comb begin
    sel_line = 1'b0;
    for (int i = 1; i <= GEI_NUM; i++) begin
      if (vgein_i == VGEIN_W'(i)) sel_line = gpend_o[i];
    end
  end

  assign hpend_o.ext = hvip_i.ext | sel_line | vs_ext_irq_i;
  assign hpend_o.tmr = hvip_i.tmr | vs_tmr_irq_i;
  assign hpend_o.ssw = hvip_i.ssw;
endmodule

// File: rtl/hyp_irq_rmux.sv
`timescale 1ns/1ps
module hyp_irq_rmux
  import hyp_irq_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [11:0]     addr_i,
  input  vs_bits_t        deleg_i,
  input  logic            deleg_lcof_i,
  input  vs_bits_t        hen_i,
  input  logic            hen_sge_i,
  input  vs_bits_t        hvip_i,
  input  vs_bits_t        hpend_i,
  input  logic            sgeip_i,
  input  logic [XLEN-1:0] geen_i,
  input  logic [XLEN-1:0] gpend_i,
  input  logic [XLEN-1:0] scratch_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            unmapped_o
);
  localparam int LO = B_SSW - VS_SHIFT;
  localparam int MO = B_TMR - VS_SHIFT;
  localparam int HO = B_EXT - VS_SHIFT;

  vs_bits_t vs_en, vs_pd;

  assign vs_en = deleg_i & hen_i;
  assign vs_pd = deleg_i & hpend_i;

  always_comb begin
    rdata_o    = '0;
    unmapped_o = 1'b0;
    unique case (addr_i)
      A_HDELEG: begin
        rdata_o[B_SSW]  = deleg_i.ssw;
        rdata_o[B_TMR]  = deleg_i.tmr;
        rdata_o[B_EXT]  = deleg_i.ext;
        rdata_o[B_LCOF] = deleg_lcof_i;
      end
      A_HEN: begin
        rdata_o[B_SSW] = hen_i.ssw;
        rdata_o[B_TMR] = hen_i.tmr;
        rdata_o[B_EXT] = hen_i.ext;
        rdata_o[B_SGE] = hen_sge_i;
      end
      A_GEEN:   rdata_o = geen_i;
      A_GEPEND: rdata_o = gpend_i;
      A_HPEND: begin
        rdata_o[B_SSW] = hpend_i.ssw;
        rdata_o[B_TMR] = hpend_i.tmr;
        rdata_o[B_EXT] = hpend_i.ext;
        rdata_o[B_SGE] = sgeip_i;
      end
      A_HVPEND: begin
        rdata_o[B_SSW] = hvip_i.ssw;
        rdata_o[B_TMR] = hvip_i.tmr;
        rdata_o[B_EXT] = hvip_i.ext;
      end
      A_VSEN: begin
        rdata_o[LO] = vs_en.ssw;
        rdata_o[MO] = vs_en.tmr;
        rdata_o[HO] = vs_en.ext;
      end
      A_VSPEND: begin
        rdata_o[LO] = vs_pd.ssw;
        rdata_o[MO] = vs_pd.tmr;
        rdata_o[HO] = vs_pd.ext;
      end
      A_VSSCR:  rdata_o = scratch_i;
      default:  unmapped_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/hyp_irq_csr.sv
`timescale 1ns/1ps
module hyp_irq_csr
  import hyp_irq_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int GEI_NUM    = 4,
  parameter int VGEIN_W    = 6,
  parameter bit LCOF_DELEG = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               csr_unmapped_o,
  input  logic [XLEN-1:0]    gext_pend_i,
  input  logic [VGEIN_W-1:0] vgein_i,
  input  logic               vs_ext_irq_i,
  input  logic               vs_tmr_irq_i,
  output logic [XLEN-1:0]    hip_o
);
  vs_bits_t deleg, hen, hvip, hpend;
  logic deleg_lcof, hen_sge, sgeip;
  logic [XLEN-1:0] geen, gpend, scratch;

  hyp_irq_regs #(.XLEN(XLEN), .GEI_NUM(GEI_NUM), .LCOF_DELEG(LCOF_DELEG)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (csr_addr_i),
    .we_i         (csr_we_i),
    .wdata_i      (csr_wdata_i),
    .deleg_o      (deleg),
    .deleg_lcof_o (deleg_lcof),
    .hen_o        (hen),
    .hen_sge_o    (hen_sge),
    .hvip_o       (hvip),
    .geen_o       (geen),
    .scratch_o    (scratch)
  );

  hyp_irq_pend #(.XLEN(XLEN), .GEI_NUM(GEI_NUM), .VGEIN_W(VGEIN_W)) i_pend (
    .hvip_i       (hvip),
    .geen_i       (geen),
    .gext_pend_i  (gext_pend_i),
    .vgein_i      (vgein_i),
    .vs_ext_irq_i (vs_ext_irq_i),
    .vs_tmr_irq_i (vs_tmr_irq_i),
    .gpend_o      (gpend),
    .hpend_o      (hpend),
    .sgeip_o      (sgeip)
  );

  hyp_irq_rmux #(.XLEN(XLEN)) i_rmux (
    .addr_i       (csr_addr_i),
    .deleg_i      (deleg),
    .deleg_lcof_i (deleg_lcof),
    .hen_i        (hen),
    .hen_sge_i    (hen_sge),
    .hvip_i       (hvip),
    .hpend_i      (hpend),
    .sgeip_i      (sgeip),
    .geen_i       (geen),
    .gpend_i      (gpend),
    .scratch_i    (scratch),
    .rdata_o      (csr_rdata_o),
    .unmapped_o   (csr_unmapped_o)
  );

  always_comb begin
    hip_o        = '0;
    hip_o[B_SSW] = hpend.ssw;
    hip_o[B_TMR] = hpend.tmr;
    hip_o[B_EXT] = hpend.ext;
    hip_o[B_SGE] = sgeip;
  end
endmodule

// File: rtl/hyp_irq_chk.sv
`timescale 1ns/1ps
module hyp_irq_chk
  import hyp_irq_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int GEI_NUM = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [11:0]     csr_addr_i,
  input logic            csr_we_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [XLEN-1:0] csr_rdata_o,
  input logic            csr_unmapped_o,
  input logic [XLEN-1:0] gext_pend_i,
  input logic            vs_ext_irq_i,
  input logic            vs_tmr_irq_i,
  input logic [XLEN-1:0] hip_o
);
  localparam logic [XLEN-1:0] GE_MASK = XLEN'(ge_mask_f(GEI_NUM));
  localparam logic [XLEN-1:0] VP_MASK = XLEN'(64'h444);

  p_unmapped_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_unmapped_o |-> (csr_rdata_o == '0));

  p_gepend_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_GEPEND) |-> ((csr_rdata_o & ~GE_MASK) == '0));

  p_geen_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_GEEN) |-> ((csr_rdata_o & ~GE_MASK) == '0));

  p_sgei_needs_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hip_o[B_SGE] |-> ((gext_pend_i & GE_MASK) != '0));

  p_ext_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_ext_irq_i |-> hip_o[B_EXT]);

  p_tmr_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_tmr_irq_i |-> hip_o[B_TMR]);

  p_hvip_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_HVPEND) |-> ((csr_rdata_o & ~VP_MASK) == '0));

  p_scratch_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == A_VSSCR) ##1 (csr_addr_i == A_VSSCR)
      |-> (csr_rdata_o == $past(csr_wdata_i)));
endmodule

bind hyp_irq_csr hyp_irq_chk #(.XLEN(XLEN), .GEI_NUM(GEI_NUM)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .csr_addr_i     (csr_addr_i),
  .csr_we_i       (csr_we_i),
  .csr_wdata_i    (csr_wdata_i),
  .csr_rdata_o    (csr_rdata_o),
  .csr_unmapped_o (csr_unmapped_o),
  .gext_pend_i    (gext_pend_i),
  .vs_ext_irq_i   (vs_ext_irq_i),
  .vs_tmr_irq_i   (vs_tmr_irq_i),
  .hip_o          (hip_o)
);

// File: tb/test_hyp_irq_csr.sv
`timescale 1ns/1ps
module test_hyp_irq_csr;
  localparam int  XLEN    = 64;
  localparam int  VGEIN_W = 6;
  localparam time CLK_T   = 10ns;
  localparam int  NVEC    = 28;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [11:0] addr;
    logic [15:0] wd;
    logic [7:0]  gp;
    logic [5:0]  vg;
    logic        ext;
    logic        tmr;
    logic [15:0] exp_rd;
    logic [15:0] exp_hip;
  } vec_t;

  function automatic vec_t v(logic [3:0] req, logic wr, logic [11:0] a, logic [15:0] d,
                             logic [7:0] g, logic [5:0] vg, logic e, logic t,
                             logic [15:0] er, logic [15:0] eh);
    return '{req: req, wr: wr, addr: a, wd: d, gp: g, vg: vg, ext: e, tmr: t,
             exp_rd: er, exp_hip: eh};
  endfunction

  // GEI_NUM=4 -> guest-external mask 0x1E; LCOF_DELEG=0
  localparam vec_t TBL [NVEC] = '{
    v(2,  1, 12'h607, 16'hFFFF, 8'h00, 0, 0, 0, 16'h001E, 16'h0000), // R2
    v(3,  0, 12'hE12, 16'h0000, 8'hFF, 0, 0, 0, 16'h001E, 16'h1000), // R3 mask, R4
    v(3,  1, 12'hE12, 16'hFFFF, 8'h00, 0, 0, 0, 16'h0000, 16'h0000), // R3 write ignored
    v(4,  0, 12'h608, 16'h0000, 8'hFF, 0, 0, 0, 16'h1000, 16'h1000), // R4
    v(4,  1, 12'h607, 16'h0004, 8'h08, 0, 0, 0, 16'h0004, 16'h0000), // R4 no overlap
    v(5,  0, 12'h608, 16'h0000, 8'h08, 3, 0, 0, 16'h0400, 16'h0400), // R5 select, enable off
    v(5,  0, 12'h608, 16'h0000, 8'h21, 5, 0, 0, 16'h0000, 16'h0000), // R5 sel > GEI_NUM
    v(5,  0, 12'h608, 16'h0000, 8'h21, 0, 0, 0, 16'h0000, 16'h0000), // R5 sel 0
    v(5,  0, 12'h608, 16'h0000, 8'h00, 0, 1, 0, 16'h0400, 16'h0400), // R5 ext line
    v(6,  0, 12'h608, 16'h0000, 8'h00, 0, 0, 1, 16'h0040, 16'h0040), // R6 timer line
    v(8,  1, 12'h645, 16'hFFFF, 8'h00, 0, 0, 0, 16'h0444, 16'h0444), // R8
    v(6,  1, 12'h608, 16'h0000, 8'h00, 0, 0, 0, 16'h0440, 16'h0440), // R6 only bit2
    v(6,  0, 12'h645, 16'h0000, 8'h00, 0, 0, 0, 16'h0440, 16'h0440), // R6 alias landed
    v(8,  1, 12'h604, 16'hFFFF, 8'h00, 0, 0, 0, 16'h1444, 16'h0440), // R8
    v(7,  1, 12'h603, 16'hFFFF, 8'h00, 0, 0, 0, 16'h0444, 16'h0440), // R7
    v(9,  0, 12'h204, 16'h0000, 8'h00, 0, 0, 0, 16'h0222, 16'h0440), // R9
    v(10, 0, 12'h244, 16'h0000, 8'h00, 0, 0, 0, 16'h0220, 16'h0440), // R10
    v(10, 1, 12'h244, 16'h0002, 8'h00, 0, 0, 0, 16'h0222, 16'h0444), // R10 set ssw
    v(10, 1, 12'h244, 16'h0000, 8'h00, 0, 0, 0, 16'h0220, 16'h0440), // R10 clear ssw only
    v(9,  1, 12'h204, 16'h0020, 8'h00, 0, 0, 0, 16'h0020, 16'h0440), // R9 redirect
    v(9,  0, 12'h604, 16'h0000, 8'h00, 0, 0, 0, 16'h1040, 16'h0440), // R9 landed, bit12 kept
    v(7,  1, 12'h603, 16'h0000, 8'h00, 0, 0, 0, 16'h0000, 16'h0440), // R7 clear
    v(9,  0, 12'h204, 16'h0000, 8'h00, 0, 0, 0, 16'h0000, 16'h0440), // R9 gated
    v(9,  1, 12'h204, 16'hFFFF, 8'h00, 0, 0, 0, 16'h0000, 16'h0440), // R9 write blocked
    v(9,  0, 12'h604, 16'h0000, 8'h00, 0, 0, 0, 16'h1040, 16'h0440), // R9 unchanged
    v(10, 1, 12'h244, 16'h0002, 8'h00, 0, 0, 0, 16'h0000, 16'h0440), // R10 write blocked
    v(10, 0, 12'h645, 16'h0000, 8'h00, 0, 0, 0, 16'h0440, 16'h0440), // R10 unchanged
    v(12, 1, 12'h123, 16'hFFFF, 8'h00, 0, 0, 0, 16'h0000, 16'h0440)  // R12
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [11:0]        addr = '0;
  logic               we = 1'b0;
  logic [XLEN-1:0]    wdata = '0;
  logic [XLEN-1:0]    rdata;
  logic               unmapped;
  logic [XLEN-1:0]    gpend = '0;
  logic [VGEIN_W-1:0] vgein = '0;
  logic               ext = 1'b0;
  logic               tmr = 1'b0;
  logic [XLEN-1:0]    hip;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  hyp_irq_csr #(.XLEN(XLEN), .GEI_NUM(4), .VGEIN_W(VGEIN_W), .LCOF_DELEG(1'b0)) i_hyp_irq_csr (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .csr_addr_i     (addr),
    .csr_we_i       (we),
    .csr_wdata_i    (wdata),
    .csr_rdata_o    (rdata),
    .csr_unmapped_o (unmapped),
    .gext_pend_i    (gpend),
    .vgein_i        (vgein),
    .vs_ext_irq_i   (ext),
    .vs_tmr_irq_i   (tmr),
    .hip_o          (hip)
  );

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd_at(logic [11:0] a);
    @(negedge clk);
    addr = a;
    we = 1'b0;
    #1;
  endtask

  task automatic wr_at(logic [11:0] a, logic [XLEN-1:0] d);
    @(negedge clk);
    addr = a;
    wdata = d;
    we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_at(12'h603); chk("R1 deleg", rdata, '0);
    rd_at(12'h604); chk("R1 hen", rdata, '0);
    rd_at(12'h607); chk("R1 geen", rdata, '0);
    rd_at(12'h645); chk("R1 hvip", rdata, '0);
    rd_at(12'h240); chk("R1 scratch", rdata, '0);
    chk("R1 hip", hip, '0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      addr  = TBL[i].addr;
      wdata = XLEN'(TBL[i].wd);
      gpend = XLEN'(TBL[i].gp);
      vgein = TBL[i].vg;
      ext   = TBL[i].ext;
      tmr   = TBL[i].tmr;
      we    = TBL[i].wr;
      if (TBL[i].wr) begin
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
      end
      #1;
      chk($sformatf("R%0d row %0d rdata", TBL[i].req, i), rdata, XLEN'(TBL[i].exp_rd));
      chk($sformatf("R%0d row %0d hip", TBL[i].req, i), hip, XLEN'(TBL[i].exp_hip));
    end

    // R12 flag
    rd_at(12'h123); chk("R12 unmapped flag", 64'(unmapped), 64'd1);
    rd_at(12'hE12); chk("R12 mapped flag", 64'(unmapped), 64'd0);

    // R11 full-width scratch, no side effect
    wr_at(12'h240, 64'hDEAD_BEEF_0123_4567);
    chk("R11 scratch", rdata, 64'hDEAD_BEEF_0123_4567);
    chk("R11 hip unchanged", hip, 64'h440);
    rd_at(12'h645); chk("R11 hvip unchanged", rdata, 64'h440);

    // R2 upper bits of a full-width write
    wr_at(12'h607, 64'hFFFF_FFFF_FFFF_FFE1);
    chk("R2 high bits", rdata, 64'h0000_0000_0000_0000);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    rd_at(12'h645); chk("R1 hvip after reset", rdata, '0);
    rd_at(12'h240); chk("R1 scratch after reset", rdata, '0);
    chk("R1 hip after reset", hip, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule